// File: doc/BRIEF.md
# Glitch-Free Selectable Card Clock Divider

This block derives a card clock from a fast reference clock. A two-bit select picks one of four rates: the reference itself, or the reference divided by 2, 4 or 8. Software or a controller may change the select while the card clock is running. The block retimes the select into the reference domain and moves to the new rate only at points where the old waveform has just finished a pulse and the new one can begin with a full low phase. As a result, no runt pulse ever appears on the card pin.

An enable input gates the clock toward the card. While it is low, the output stays low. Enable passes through the same retiming path as the select. Its rises and falls take effect only on aligned boundaries, so the first pulse and the last pulse are both whole.

A single free-running phase counter drives every ratio. Each divided output is one bit of that counter, registered. The pass-through rate uses the reference high phase, gated by a flop that updates on the falling edge of the reference, so the gate never changes while the reference is high.

Top module: `card_clk_divider`

## Requirements
- R1: The select code sets the ratio: 2'b10 passes the reference through, 2'b11 divides by 2, 2'b01 divides by 4, and 2'b00 divides by 8. In steady state each divided output has a period of N reference cycles with N/2 cycles high.
- R2: The select and enable inputs reach the ratio logic only through SYNC_STAGES (default 2) flops in the reference domain. No change on those pins can affect the output earlier than that.
- R3: A ratio change is applied only where the phase counter is aligned to the longer of the old and new periods. At that point the output has just gone low. Every high pulse around a change has the full width of its own ratio, and no low phase is shorter than the shorter of the two half-periods.
- R4: During a ratio change, no output level is shorter than 45% of the shorter of the two periods involved.
- R5: After the select changes, the new ratio is in effect within SYNC_STAGES plus the longer period, counted in reference cycles. This is 10 cycles for a change between divide-by-4 and divide-by-8.
- R6: While the retimed enable is low, the output is held low. A fall of enable takes effect on an aligned boundary, so the last high pulse has full width.
- R7: After enable rises, the output starts with a low phase and then gives a first high pulse of full width for the selected ratio.
- R8: During and after reset the output is low, the ratio is divide-by-8 and the output is disabled. The output shows no edge until enable is raised.
- R9: In pass-through mode the output high phases coincide with the reference high phases. The pass-through gate opens and closes only while the reference is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Rate select code (Gray ordered) |
| enable | input | 1 | Releases the card clock when high |
| clk_out | output | 1 | Card clock |

## Verification
The bench timestamps every edge of the card clock while each of the eight single-bit select changes is made, including the ring step between pass-through and divide-by-8. It flags any high pulse that is not a full pulse of the old or new ratio, and any level shorter than the runt limit. A design that switched on an unaligned count would show a clipped high pulse or a sliver of low. A design that gated the pass-through path on the rising edge would show a zero-width spike. A design with a slow or doubled synchronizer would still show the old pulse width when the bench measures the first pulse after the latency bound. A design that released enable off-boundary would produce a short first pulse or a short last pulse in the enable and disable scenarios.

// File: rtl/ccd_pkg.sv
`timescale 1ns/1ps
package ccd_pkg;
  localparam int unsigned CCD_LOG2_MAX = 3;
  localparam int unsigned CCD_CNT_W    = CCD_LOG2_MAX;
  localparam int unsigned CCD_LOG2_W   = $clog2(CCD_LOG2_MAX + 1);
  localparam int unsigned CCD_SEL_W    = 2;

  typedef logic [CCD_CNT_W-1:0]  ccd_cnt_t;
  typedef logic [CCD_LOG2_W-1:0] ccd_log2_t;
  typedef logic [CCD_SEL_W-1:0]  ccd_sel_t;

  // select code -> log2 of the division ratio (Gray ring 10,11,01,00)
  function automatic ccd_log2_t ccd_sel_to_log2(ccd_sel_t s);
    case (s)
      2'b10:   return ccd_log2_t'(0);
      2'b11:   return ccd_log2_t'(1);
      2'b01:   return ccd_log2_t'(2);
      default: return ccd_log2_t'(3);
    endcase
  endfunction

  // counter bits that must be zero at a period boundary of 2**k
  function automatic ccd_cnt_t ccd_period_mask(ccd_log2_t k);
    return ccd_cnt_t'((32'd1 << k) - 32'd1);
  endfunction

  // output level of ratio 2**k at phase c: bit k-1 of c, zero for k == 0
  function automatic logic ccd_phase_level(ccd_cnt_t c, ccd_log2_t k);
    logic [CCD_CNT_W:0] ext;
    ext = {c, 1'b0};
    return ext[k];
  endfunction

  function automatic ccd_log2_t ccd_max_log2(ccd_log2_t a, ccd_log2_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ccd_sync.sv
`timescale 1ns/1ps
module ccd_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ccd_phase_ctr.sv
`timescale 1ns/1ps
module ccd_phase_ctr
  import ccd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  output ccd_cnt_t cnt_q,
  output ccd_cnt_t cnt_nxt
);
  assign cnt_nxt = cnt_q + ccd_cnt_t'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/ccd_ratio_ctrl.sv
`timescale 1ns/1ps
module ccd_ratio_ctrl
  import ccd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ccd_cnt_t  cnt_nxt,
  input  ccd_sel_t  sel_s,
  input  logic      en_s,
  output ccd_log2_t ratio_act,
  output logic      en_act,
  output ccd_log2_t ratio_nxt,
  output logic      en_nxt,
  output logic      switch_pt
);
  ccd_log2_t k_req;
  ccd_log2_t k_big;

  always_comb begin
    k_req     = ccd_sel_to_log2(sel_s);
    k_big     = ccd_max_log2(ratio_act, k_req);
    switch_pt = ((cnt_nxt & ccd_period_mask(k_big)) == '0);
    ratio_nxt = switch_pt ? k_req : ratio_act;
    en_nxt    = switch_pt ? en_s  : en_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_act <= ccd_log2_t'(CCD_LOG2_MAX);
      en_act    <= 1'b0;
    end else begin
      ratio_act <= ratio_nxt;
      en_act    <= en_nxt;
    end
  end
endmodule

// File: rtl/ccd_clk_gen.sv
`timescale 1ns/1ps
module ccd_clk_gen
  import ccd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ccd_cnt_t  cnt_nxt,
  input  ccd_log2_t ratio_nxt,
  input  logic      en_nxt,
  output logic      div_q,
  output logic      pass_q,
  output logic      pass_gate_n,
  output logic      clk_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      div_q  <= en_nxt & ccd_phase_level(cnt_nxt, ratio_nxt);
      pass_q <= en_nxt & (ratio_nxt == '0);
    end
  end

  // gate retimed on the falling edge: it only moves while clk is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pass_gate_n <= 1'b0;
    else        pass_gate_n <= pass_q;
  end

  assign clk_out = div_q | (clk & pass_gate_n);
endmodule

// File: rtl/card_clk_divider.sv
`timescale 1ns/1ps
module card_clk_divider
  import ccd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 ref_clk,
  input  logic                 rst_n,
  input  logic [CCD_SEL_W-1:0] sel,
  input  logic                 enable,
  output logic                 clk_out
);
  localparam int unsigned REQ_W = CCD_SEL_W + 1;

  logic [REQ_W-1:0] req_raw;
  logic [REQ_W-1:0] req_s;
  ccd_sel_t         sel_s;
  logic             en_s;
  ccd_cnt_t         cnt_q;
  ccd_cnt_t         cnt_nxt;
  ccd_log2_t        ratio_act;
  ccd_log2_t        ratio_nxt;
  logic             en_act;
  logic             en_nxt;
  logic             switch_pt;
  logic             div_q;
  logic             pass_q;
  logic             pass_gate_n;

  assign req_raw = {enable, sel};
  assign sel_s   = req_s[CCD_SEL_W-1:0];
  assign en_s    = req_s[CCD_SEL_W];

  ccd_sync #(.WIDTH(REQ_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(ref_clk), .rst_n(rst_n), .d(req_raw), .q(req_s)
  );

  ccd_phase_ctr ctr_i (
    .clk(ref_clk), .rst_n(rst_n), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  ccd_ratio_ctrl ctrl_i (
    .clk(ref_clk), .rst_n(rst_n), .cnt_nxt(cnt_nxt), .sel_s(sel_s),
    .en_s(en_s), .ratio_act(ratio_act), .en_act(en_act),
    .ratio_nxt(ratio_nxt), .en_nxt(en_nxt), .switch_pt(switch_pt)
  );

  ccd_clk_gen gen_i (
    .clk(ref_clk), .rst_n(rst_n), .cnt_nxt(cnt_nxt), .ratio_nxt(ratio_nxt),
    .en_nxt(en_nxt), .div_q(div_q), .pass_q(pass_q),
    .pass_gate_n(pass_gate_n), .clk_out(clk_out)
  );
endmodule

// File: rtl/ccd_checker.sv
`timescale 1ns/1ps
module ccd_checker
  import ccd_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input ccd_cnt_t  cnt_q,
  input ccd_log2_t ratio_act,
  input logic      en_act,
  input logic      div_q,
  input logic      pass_q,
  input logic      pass_gate_n
);
  // R3
  ratio_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_act) |-> (((cnt_q & ccd_period_mask(ratio_act)) == '0) &&
                            ((cnt_q & ccd_period_mask($past(ratio_act))) == '0)));

  // R3
  switch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_act) |-> !div_q);

  // R1
  div_edge_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(div_q) && $stable(ratio_act) && $stable(en_act)) |->
      ((cnt_q & (ccd_period_mask(ratio_act) >> 1)) == '0));

  // R6
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_act |-> (!div_q && !pass_q));

  // R6
  en_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_act) |-> (((cnt_q & ccd_period_mask(ratio_act)) == '0) && !div_q));

  // R9
  pass_gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q |-> !div_q);

  // R9
  gate_stable_high_chk: assert property (@(negedge clk) disable iff (!rst_n)
    pass_gate_n |-> !div_q);
endmodule

bind card_clk_divider ccd_checker chk_i (
  .clk(ref_clk), .rst_n(rst_n), .cnt_q(cnt_q), .ratio_act(ratio_act),
  .en_act(en_act), .div_q(div_q), .pass_q(pass_q), .pass_gate_n(pass_gate_n)
);

// File: tb/card_clk_divider_tb_top.sv
`timescale 1ns/1ps
module card_clk_divider_tb_top;
  localparam realtime CLK_PERIOD = 10.0;
  localparam int      SYNC       = 2;

  logic       ref_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic [1:0] sel     = 2'b00;
  logic       enable  = 1'b0;
  logic       clk_out;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 0;

  // edge monitor
  realtime last_t   = 0.0;
  int      edge_cnt = 0;
  bit      mon_on   = 0;
  realtime mon_ha   = 0.0;
  realtime mon_hb   = 0.0;
  realtime mon_min  = 0.0;
  realtime bad_w    = 0.0;
  int      mon_bad  = 0;

  card_clk_divider #(.SYNC_STAGES(SYNC)) dut_i (
    .ref_clk(ref_clk), .rst_n(rst_n), .sel(sel), .enable(enable),
    .clk_out(clk_out)
  );

  always #(CLK_PERIOD / 2.0) ref_clk = ~ref_clk;

  always @(clk_out) begin
    realtime w;
    w = $realtime - last_t;
    edge_cnt++;
    if (mon_on) begin
      if (w < mon_min) mon_min = w;
      if (!clk_out && w != mon_ha && w != mon_hb) begin
        mon_bad++;
        bad_w = w;
      end
    end
    last_t = $realtime;
  end

  // period in reference cycles for a select code (R1 encoding)
  function automatic int per_cyc(logic [1:0] s);
    case (s)
      2'b10:   return 1;
      2'b11:   return 2;
      2'b01:   return 4;
      default: return 8;
    endcase
  endfunction

  function automatic realtime half_w(logic [1:0] s);
    return CLK_PERIOD * per_cyc(s) / 2.0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input realtime act, input realtime exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  task automatic measure(output realtime hi, output realtime per);
    realtime t0, t1, t2;
    @(posedge clk_out) t0 = $realtime;
    @(negedge clk_out) t1 = $realtime;
    @(posedge clk_out) t2 = $realtime;
    hi  = t1 - t0;
    per = t2 - t0;
  endtask

  // R8: quiet and low out of reset while disabled
  task automatic t_reset();
    int e0;
    check(clk_out == 1'b0, "R8", "clk_out in reset", clk_out, 0);
    @(negedge ref_clk) rst_n = 1'b1;
    e0 = edge_cnt;
    repeat (40) @(posedge ref_clk);
    @(negedge ref_clk);
    check(edge_cnt == e0 && clk_out == 1'b0, "R8", "edges while disabled",
          edge_cnt - e0, 0);
  endtask

  // R7, R2: release the clock
  task automatic t_enable(input logic [1:0] s);
    realtime te, tr, hi, per;
    realtime lo_b, hi_b;
    @(negedge ref_clk) sel = s;
    repeat (20) @(posedge ref_clk);
    @(negedge ref_clk) begin enable = 1'b1; te = $realtime; end
    @(posedge clk_out) tr = $realtime;
    lo_b = (SYNC + 0.5) * CLK_PERIOD + half_w(s);
    hi_b = (SYNC + 0.5 + per_cyc(s)) * CLK_PERIOD + half_w(s);
    check(tr - te >= lo_b, "R2", "first rise after enable too early", tr - te, lo_b);
    check(tr - te <= hi_b, "R7", "first rise after enable too late", tr - te, hi_b);
    @(negedge clk_out);
    hi = $realtime - tr;
    check(hi == half_w(s), "R7", "first high width", hi, half_w(s));
    measure(hi, per);
  endtask

  // R6: stop the clock on a boundary
  task automatic t_disable(input logic [1:0] s);
    int e0;
    mon_ha = half_w(s); mon_hb = half_w(s); mon_bad = 0; mon_min = 1.0e9;
    mon_on = 1;
    @(negedge ref_clk) enable = 1'b0;
    repeat (SYNC + per_cyc(s) + 1) @(posedge ref_clk);
    @(negedge ref_clk);
    mon_on = 0;
    check(mon_bad == 0, "R6", "last high pulse width", bad_w, half_w(s));
    e0 = edge_cnt;
    repeat (40) @(posedge ref_clk);
    @(negedge ref_clk);
    check(edge_cnt == e0 && clk_out == 1'b0, "R6", "edges after disable",
          edge_cnt - e0, 0);
  endtask

  // R1, R9: steady waveform per select code
  task automatic t_steady(input logic [1:0] s);
    realtime hi, per;
    @(negedge ref_clk) sel = s;
    repeat (24) @(posedge ref_clk);
    measure(hi, per);
    check(hi == half_w(s), (s == 2'b10) ? "R9" : "R1", "steady high width",
          hi, half_w(s));
    check(per == 2.0 * half_w(s), "R1", "steady period", per, 2.0 * half_w(s));
  endtask

  // R3, R4, R5: one single-bit select change
  task automatic t_transition(input logic [1:0] from_s, input logic [1:0] to_s);
    realtime hi, per, lim;
    int big;
    @(negedge ref_clk) sel = from_s;
    repeat (24) @(posedge ref_clk);
    mon_ha = half_w(from_s); mon_hb = half_w(to_s);
    mon_bad = 0; mon_min = 1.0e9; mon_on = 1;
    big = (per_cyc(from_s) > per_cyc(to_s)) ? per_cyc(from_s) : per_cyc(to_s);
    @(negedge ref_clk) sel = to_s;
    repeat (SYNC + big) @(posedge ref_clk);
    measure(hi, per);
    check(hi == half_w(to_s) && per == 2.0 * half_w(to_s), "R5",
          "first pulse after latency bound", hi, half_w(to_s));
    repeat (2 * per_cyc(to_s)) @(posedge ref_clk);
    mon_on = 0;
    check(mon_bad == 0, "R3", "high pulse width around change", bad_w, mon_hb);
    lim = (mon_ha < mon_hb) ? mon_ha : mon_hb;
    check(mon_min >= 0.9 * lim, "R4", "shortest level during change",
          mon_min, 0.9 * lim);
  endtask

  initial begin
    repeat (4) @(posedge ref_clk);
    t_reset();
    t_enable(2'b01);
    t_steady(2'b10);
    t_steady(2'b11);
    t_steady(2'b01);
    t_steady(2'b00);
    t_transition(2'b00, 2'b01);
    t_transition(2'b01, 2'b11);
    t_transition(2'b11, 2'b10);
    t_transition(2'b10, 2'b00);
    t_transition(2'b00, 2'b10);
    t_transition(2'b10, 2'b11);
    t_transition(2'b11, 2'b01);
    t_transition(2'b01, 2'b00);
    @(negedge ref_clk) sel = 2'b01;
    repeat (24) @(posedge ref_clk);
    t_disable(2'b01);
    t_enable(2'b10);
    t_disable(2'b10);
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule